// File: doc/BRIEF.md
# Serial Command and Fault-Status Slave for an Eight-Channel Driver

This block is the serial front end of a controller for eight output drivers. A host master sends 16-bit command words over a four-wire serial link: clock, active-low select, data in and data out. During the same frame the block returns a status word holding one fault flag per driver. The serial clock and select lines are brought into the fast system clock domain through synchronisers. All edge handling runs on those synchronised samples, so the serial clock must be several times slower than the system clock.

When select falls, the current fault flags are frozen into the transmit register and the data-out driver turns on. Serial data is sampled on each rising edge of the serial clock. The transmit register advances on each falling edge, so the master can read a stable bit at the next rising edge. When select rises, the data-out driver turns off. If the frame was well formed, its low command byte then becomes the new driver-on pattern. An enable input puts the block into sleep. Sleep clears the driver pattern and ignores all serial traffic.

Top module: `spi_drv_ctrl`

## Requirements
- R1: After the synchronous reset, all eight `drv_on` bits are 0 and `sdo_oe` is 0.
- R2: `sdo_oe` goes to 1 after select falls while `en` is 1, and returns to 0 after select rises.
- R3: The status word is 16 bits and goes out most significant bit first. Bits [15:8] are 0, and bit k (k = 0..7) is `fault_flags[k]`, where 1 means driver k+1 is faulted and 0 means it is healthy. The first bit appears on `sdo` after select falls, and each later bit appears after a falling edge of the serial clock.
- R4: The status word is the value of `fault_flags` at the falling edge of select. Changes to `fault_flags` during the frame do not alter the bits shifted out.
- R5: The command is shifted in most significant bit first on rising serial clock edges. At the rising edge of select, command bits [7:0] become `drv_on[7:0]`, so bit k drives output k+1. Command bits [15:8] are ignored.
- R6: A command is applied only if exactly 16 rising serial clock edges occurred while select was low. A frame with 15 or 17 edges leaves `drv_on` unchanged.
- R7: While select is high, activity on the serial clock and data-in lines changes neither `drv_on` nor `sdo_oe`.
- R8: While `en` is 0 (sleep), `drv_on` is cleared to 0, `sdo_oe` stays 0, and whole frames on the serial lines have no effect. Once `en` returns to 1, frames work normally again.
- R9: `drv_on` changes only in the cycle after a valid commit, or when sleep clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | 1 = normal mode, 0 = sleep |
| sclk_in | input | 1 | Serial clock from the master (asynchronous) |
| csn_in | input | 1 | Active-low frame select (asynchronous) |
| sdi | input | 1 | Serial command data in |
| fault_flags | input | 8 | Per-driver fault flags, 1 = faulted |
| sdo | output | 1 | Serial status data out |
| sdo_oe | output | 1 | Output enable for the `sdo` pad driver |
| drv_on | output | 8 | Latched driver-on pattern, bit k drives output k+1 |

## Verification
The bench sweeps many command and fault patterns. It checks every shifted status bit against a word it builds itself. A design that shifts least significant bit first, or on the wrong clock edge, would return a reversed or skewed status word. Short (15-edge) and long (17-edge) frames must leave the driver pattern alone; a design that skips the edge count would latch a shifted byte. The bench changes the fault flags in mid-frame to catch a design that samples status late instead of at select fall. It also drives serial clock bursts with select high, and full frames during sleep, which would otherwise corrupt the next command or switch drivers on while asleep.

// File: rtl/spi_drv_pkg.sv
package spi_drv_pkg;

  // Synchronised view of one asynchronous input line.
  typedef struct packed {
    logic lvl;
    logic rise;
    logic fall;
  } edge_t;

  localparam int unsigned SYNC_DEPTH_DEF = 2;

endpackage

// File: rtl/sync_edge.sv
module sync_edge
  import spi_drv_pkg::*;
#(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  din,
  output edge_t ev
);

  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= {STAGES{RST_VAL}};
      prev_q <= RST_VAL;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], din};
      prev_q <= sh_q[STAGES-1];
    end
  end

  always_comb begin
    ev.lvl  = sh_q[STAGES-1];
    ev.rise = sh_q[STAGES-1] & ~prev_q;
    ev.fall = ~sh_q[STAGES-1] & prev_q;
  end

endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned CMD_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              si_bit,
  input  logic [WORD_W-1:0] status,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              commit,
  output logic [CMD_W-1:0]  cmd_bits
);

  localparam int unsigned CW     = $clog2(WORD_W + 2);
  localparam logic [CW-1:0] FULL = CW'(WORD_W);
  localparam logic [CW-1:0] OVER = CW'(WORD_W + 1);

  logic              active_q;
  logic [CW-1:0]     cnt_q;
  logic [WORD_W-1:0] tx_q;
  logic [CMD_W-1:0]  rx_q;
  logic              commit_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
      commit_q <= 1'b0;
    end else begin
      commit_q <= 1'b0;
      if (cs_fall) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
        tx_q     <= status;
      end else if (active_q) begin
        if (cs_rise) begin
          active_q <= 1'b0;
          commit_q <= (cnt_q == FULL);
        end else begin
          if (sclk_rise) begin
            rx_q <= {rx_q[CMD_W-2:0], si_bit};
            if (cnt_q != OVER) cnt_q <= cnt_q + 1'b1;
          end
          if (sclk_fall) tx_q <= {tx_q[WORD_W-2:0], 1'b0};
        end
      end
    end
  end

  assign sdo      = tx_q[WORD_W-1];
  assign sdo_oe   = active_q;
  assign commit   = commit_q;
  assign cmd_bits = rx_q;

  p_cnt_sat_r6: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= OVER);

  p_oe_off_r2: assert property (@(posedge clk) disable iff (rst)
    (active_q && cs_rise) |=> !sdo_oe);

  p_snapshot_r4: assert property (@(posedge clk) disable iff (rst)
    (en && cs_fall) |=> (tx_q == $past(status)));

  p_no_commit_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !active_q |=> !commit);

endmodule

// File: rtl/cmd_reg.sv
module cmd_reg #(
  parameter int unsigned NUM_DRV = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               commit,
  input  logic [NUM_DRV-1:0] cmd_bits,
  output logic [NUM_DRV-1:0] drv_on
);

  logic [NUM_DRV-1:0] drv_q;

  always_ff @(posedge clk) begin
    if (rst || !en)   drv_q <= '0;
    else if (commit)  drv_q <= cmd_bits;
  end

  assign drv_on = drv_q;

  p_stable_r9: assert property (@(posedge clk) disable iff (rst)
    (en && !commit) |=> $stable(drv_q));

  p_apply_r5: assert property (@(posedge clk) disable iff (rst)
    (en && commit) |=> (drv_q == $past(cmd_bits)));

endmodule

// File: rtl/spi_drv_ctrl.sv
module spi_drv_ctrl
  import spi_drv_pkg::*;
#(
  parameter int unsigned WORD_W     = 16,
  parameter int unsigned NUM_DRV    = 8,
  parameter int unsigned SYNC_DEPTH = SYNC_DEPTH_DEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               sclk_in,
  input  logic               csn_in,
  input  logic               sdi,
  input  logic [NUM_DRV-1:0] fault_flags,
  output logic               sdo,
  output logic               sdo_oe,
  output logic [NUM_DRV-1:0] drv_on
);

  localparam int unsigned NLINES     = 3;
  localparam logic [NLINES-1:0] RSTV = 3'b001;  // csn idles high

  logic [NLINES-1:0] raw;
  edge_t             ev [NLINES];

  assign raw = {sdi, sclk_in, csn_in};

  for (genvar g = 0; g < NLINES; g++) begin : g_sync
    sync_edge #(.STAGES(SYNC_DEPTH), .RST_VAL(RSTV[g])) u_sync (
      .clk (clk),
      .rst (rst),
      .din (raw[g]),
      .ev  (ev[g])
    );
  end

  logic [WORD_W-1:0]  status_w;
  logic               commit;
  logic [NUM_DRV-1:0] cmd_bits;

  assign status_w = {{(WORD_W-NUM_DRV){1'b0}}, fault_flags};

  spi_shifter #(.WORD_W(WORD_W), .CMD_W(NUM_DRV)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .cs_fall   (ev[0].fall),
    .cs_rise   (ev[0].rise),
    .sclk_rise (ev[1].rise),
    .sclk_fall (ev[1].fall),
    .si_bit    (ev[2].lvl),
    .status    (status_w),
    .sdo       (sdo),
    .sdo_oe    (sdo_oe),
    .commit    (commit),
    .cmd_bits  (cmd_bits)
  );

  cmd_reg #(.NUM_DRV(NUM_DRV)) u_cmd (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .commit   (commit),
    .cmd_bits (cmd_bits),
    .drv_on   (drv_on)
  );

  p_sleep_r8: assert property (@(posedge clk) disable iff (rst)
    !en |=> (drv_on == '0 && !sdo_oe));

endmodule

// File: tb/tb_spi_drv_ctrl.sv
`timescale 1ns/1ps
module tb_spi_drv_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b1;
  logic       sclk_in = 1'b0;
  logic       csn_in = 1'b1;
  logic       sdi = 1'b0;
  logic [7:0] fault_flags = 8'h00;
  logic       sdo, sdo_oe;
  logic [7:0] drv_on;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] exp_drv = 8'h00;

  always #4 clk = ~clk;  // 125 MHz

  spi_drv_ctrl dut (
    .clk(clk), .rst(rst), .en(en), .sclk_in(sclk_in), .csn_in(csn_in),
    .sdi(sdi), .fault_flags(fault_flags), .sdo(sdo), .sdo_oe(sdo_oe),
    .drv_on(drv_on)
  );

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One frame with nedges serial clock pulses. The status check uses flt.
  task automatic frame(input logic [15:0] cmd, input int nedges,
                       input logic [7:0] flt, input bit chk_so,
                       input bit chg_flt);
    logic [15:0] st;
    st = {8'h00, flt};
    fault_flags = flt;
    wclk(2);
    csn_in = 1'b0;
    wclk(8);
    if (chk_so) chk(sdo_oe == en, "R2 oe during frame", sdo_oe, en);
    if (chg_flt) fault_flags = ~flt;
    for (int i = 0; i < nedges; i++) begin
      sdi = (i < 16) ? cmd[15-i] : 1'b0;
      wclk(8);
      if (chk_so && en) begin
        logic eb;
        eb = (i < 16) ? st[15-i] : 1'b0;
        chk(sdo == eb, chg_flt ? "R4 snapshot bit" : "R3 status bit", sdo, eb);
      end
      sclk_in = 1'b1;
      wclk(8);
      sclk_in = 1'b0;
    end
    wclk(8);
    csn_in = 1'b1;
    wclk(8);
    if (chk_so) chk(sdo_oe == 1'b0, "R2 oe after frame", sdo_oe, 0);
  endtask

  initial begin
    wclk(4);
    chk(drv_on == 8'h00, "R1 drv_on reset", drv_on, 0);
    chk(sdo_oe == 1'b0, "R1 oe reset", sdo_oe, 0);
    rst = 1'b0;
    wclk(4);

    // R3 R5 sweep of command and fault patterns
    for (int k = 0; k < 24; k++) begin
      logic [15:0] c;
      logic [7:0]  f;
      c = 16'((k * 16'h9E37) ^ (k << 3));
      f = 8'((k * 73) ^ 8'hA5);
      frame(c, 16, f, 1'b1, 1'b0);
      exp_drv = c[7:0];
      chk(drv_on == exp_drv, "R5 command applied", drv_on, exp_drv);
    end
    // R5 upper byte ignored
    frame(16'hFF00, 16, 8'h00, 1'b1, 1'b0);
    exp_drv = 8'h00;
    chk(drv_on == exp_drv, "R5 upper byte ignored", drv_on, exp_drv);
    frame(16'h00FF, 16, 8'hFF, 1'b1, 1'b0);
    exp_drv = 8'hFF;
    chk(drv_on == exp_drv, "R5 all on", drv_on, exp_drv);

    // R4 fault change in mid-frame
    frame(16'h003C, 16, 8'h5A, 1'b1, 1'b1);
    exp_drv = 8'h3C;
    chk(drv_on == exp_drv, "R4 command with fault change", drv_on, exp_drv);

    // R6 short and long frames
    frame(16'h00C3, 15, 8'h00, 1'b0, 1'b0);
    chk(drv_on == exp_drv, "R6 15 edges kept", drv_on, exp_drv);
    frame(16'h0081, 17, 8'h00, 1'b0, 1'b0);
    chk(drv_on == exp_drv, "R6 17 edges kept", drv_on, exp_drv);
    frame(16'h0000, 0, 8'h00, 1'b0, 1'b0);
    chk(drv_on == exp_drv, "R6 zero edges kept", drv_on, exp_drv);

    // R7 serial clock bursts with select high
    for (int i = 0; i < 20; i++) begin
      sdi = i[0];
      sclk_in = 1'b1; wclk(8);
      sclk_in = 1'b0; wclk(8);
      if (i == 10) chk(sdo_oe == 1'b0, "R7 oe with select high", sdo_oe, 0);
    end
    chk(drv_on == exp_drv, "R7 drv_on unchanged", drv_on, exp_drv);
    frame(16'h0099, 16, 8'h12, 1'b1, 1'b0);
    exp_drv = 8'h99;
    chk(drv_on == exp_drv, "R7 next frame clean", drv_on, exp_drv);

    // R8 sleep
    en = 1'b0;
    wclk(3);
    exp_drv = 8'h00;
    chk(drv_on == exp_drv, "R8 sleep clears", drv_on, exp_drv);
    chk(sdo_oe == 1'b0, "R8 oe in sleep", sdo_oe, 0);
    frame(16'h00F0, 16, 8'h0F, 1'b1, 1'b0);
    chk(drv_on == exp_drv, "R8 frame in sleep ignored", drv_on, exp_drv);
    en = 1'b1;
    wclk(4);
    frame(16'h0066, 16, 8'hC1, 1'b1, 1'b0);
    exp_drv = 8'h66;
    chk(drv_on == exp_drv, "R8 frame after wake", drv_on, exp_drv);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // R9 drv_on must not move outside the expected updates
  always @(negedge clk) begin
    if (!rst && en && !csn_in && !done) begin
      checks++;
      if (drv_on != exp_drv) begin
        errors++;
        $display("FAIL R9 drv_on moved in frame: actual %0h expected %0h", drv_on, exp_drv);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule